// File: doc/BRIEF.md
# Link Status Register Update Logic

This block holds the 16-bit link status register of one PCI Express switch port and the hardware that keeps it current. Each cycle it samples physical-layer and data-link-layer status: the LTSSM state, the trained width, training success, the data-link-active flag, and the current link speed. It also takes pulses for a completed software retrain, an autonomous speed or width change, and a speed or width change that the link partner started without flagging it as autonomous, plus a pulse for each write of 1 to the retrain control bit. It folds these together with the port direction, the capability fields and the common-clock strap into a single read value.

Every status field is registered, so a change at the inputs shows in `rd_data` after one rising clock edge. Register writes reach only two fields. The bandwidth status bit is cleared by writing 1 to it. The slot clock bit is writable only while its lock input is low. All other bits ignore writes.

The set of link widths the port can support is a parameter. It holds one bit per width code, in this order: x1, x2, x4, x8, x12, x16, x32. The default supports x1 through x8.

Top module: `lnk_status_reg`

## Requirements
- R1: Bits 9:4 carry the link width, coded x1=000001, x2=000010, x4=000100, x8=001000, x12=001100, x16=010000, x32=100000. When `cap_max_width` names a supported width and `train_ok` is 1, the field equals `trained_width` one cycle later.
- R2: When `cap_max_width` is not a supported width, either because it is a valid code the port lacks or because it is not a valid code, bits 9:4 equal `cap_max_width` whatever the trained width.
- R3: When `cap_max_width` is supported and `train_ok` is 0, bits 9:4 read 000000.
- R4: On a downstream port (`is_downstream`=1), bit 11 is 1 in the cycle after `ltssm_state` is Configuration (4'd2) or Recovery (4'd4). It is 0 in the cycle after any other state, unless a retrain request is pending.
- R5: A `retrain_wr` pulse sets bit 11 on the next cycle, before training starts. Bit 11 stays 1 until the LTSSM has entered Configuration or Recovery and then left it. If the pulse arrives while the LTSSM is already in Recovery, bit 11 does not drop for any cycle.
- R6: On an upstream port, bit 11 is always 0, including after `retrain_wr`.
- R7: Bit 13 equals the previous cycle's `dl_active` when `cap_dll_report` is 1. It is 0 whenever `cap_dll_report` is 0.
- R8: Bit 14 becomes 1 after a `retrain_done_evt`, `auto_change_evt` or `partner_change_evt` pulse that arrives while `dl_active` is 1. It stays 1 until a write with `wr_data[14]`=1 clears it. A write with `wr_data[14]`=0 leaves it set. Events that arrive while `dl_active` is 0 are ignored.
- R9: Bit 14 is 0, and events are ignored, whenever `cap_bw_notify` is 0 or the port is upstream.
- R10: When a set event and a clearing write of bit 14 occur in the same cycle, bit 14 ends up 1.
- R11: Bit 12 takes the value of `strap_common_clk` during reset. A write sets it to `wr_data[12]` only while `sclk_lock` is 0. While `sclk_lock` is 1, a write leaves it unchanged.
- R12: Bits 3:0 follow `phy_speed` one cycle later. Bits 10 and 15 always read 0. Right after reset every bit reads 0 except bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_downstream | input | 1 | 1 = downstream switch port, 0 = upstream |
| cap_max_width | input | 6 | Configured maximum width, in the bits 9:4 coding |
| cap_dll_report | input | 1 | Link-active reporting capability |
| cap_bw_notify | input | 1 | Bandwidth notification capability |
| strap_common_clk | input | 1 | Clocking-mode strap, reset value of bit 12 |
| ltssm_state | input | 4 | LTSSM state code (2 = Configuration, 4 = Recovery) |
| trained_width | input | 6 | Width reached by training, in the bits 9:4 coding |
| train_ok | input | 1 | Training succeeded |
| dl_active | input | 1 | Data link control state machine is active |
| phy_speed | input | 4 | Current link speed code |
| retrain_done_evt | input | 1 | Pulse: a software-started retrain completed |
| auto_change_evt | input | 1 | Pulse: PHY changed speed or width for reliability |
| partner_change_evt | input | 1 | Pulse: partner changed speed or width without flagging it autonomous |
| retrain_wr | input | 1 | Pulse: retrain control bit written with 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| sclk_lock | input | 1 | 1 blocks writes to bit 12 |
| rd_data | output | 16 | Register read value |

## Verification
The bench sweeps every pair of width codes for both values of the training result. A design that checked support against the trained width instead of the configured maximum, or that reported the trained width after a failed training, shows a wrong value in bits 9:4. It runs all 16 LTSSM codes on both port directions, and it runs a retrain request that lands while the LTSSM is already in Recovery. A training flag built only from the LTSSM state would miss the early set, and a one-cycle pending pulse would drop the flag for a cycle. The bandwidth bit is driven with a set event and a clearing write in the same cycle, with events while the link is down, and with each gating input cleared. A design that let the clear win would lose an event, and one that ignored the gates would show a set bit where the bit must read 0. The slot clock bit is tried after two resets with different straps and with writes both locked and unlocked.

// File: rtl/lnk_status_pkg.sv
package lnk_status_pkg;

  localparam int REG_W    = 16;
  localparam int SPEED_W  = 4;
  localparam int WIDTH_W  = 6;
  localparam int STATE_W  = 4;
  localparam int N_WIDTHS = 7;

  // Field positions inside the read value
  localparam int POS_SPEED = 0;
  localparam int POS_WIDTH = 4;
  localparam int POS_TRAIN = 11;
  localparam int POS_SCLK  = 12;
  localparam int POS_DLL   = 13;
  localparam int POS_BW    = 14;

  localparam logic [STATE_W-1:0] ST_CONFIG   = 4'd2;
  localparam logic [STATE_W-1:0] ST_RECOVERY = 4'd4;

  localparam logic [2:0] SLOT_NONE = 3'd7;

  // Position of a width code inside the support mask, SLOT_NONE if invalid
  function automatic logic [2:0] width_slot(input logic [WIDTH_W-1:0] code);
    logic [2:0] s;
    case (code)
      6'b000001: s = 3'd0;
      6'b000010: s = 3'd1;
      6'b000100: s = 3'd2;
      6'b001000: s = 3'd3;
      6'b001100: s = 3'd4;
      6'b010000: s = 3'd5;
      6'b100000: s = 3'd6;
      default:   s = SLOT_NONE;
    endcase
    return s;
  endfunction

  function automatic logic width_supported(input logic [WIDTH_W-1:0] code,
                                           input logic [N_WIDTHS-1:0] mask);
    logic [2:0] s;
    s = width_slot(code);
    if (s == SLOT_NONE) return 1'b0;
    return mask[s];
  endfunction

  function automatic logic is_training_state(input logic [STATE_W-1:0] st);
    return (st == ST_CONFIG) || (st == ST_RECOVERY);
  endfunction

  // Value the width field must show for a given configuration and outcome
  function automatic logic [WIDTH_W-1:0] report_width(input logic [WIDTH_W-1:0] cap,
                                                      input logic [WIDTH_W-1:0] trained,
                                                      input logic               ok,
                                                      input logic [N_WIDTHS-1:0] mask);
    if (!width_supported(cap, mask)) return cap;
    if (!ok) return '0;
    return trained;
  endfunction

endpackage

// File: rtl/lnk_width_rpt.sv
module lnk_width_rpt
  import lnk_status_pkg::*;
#(
  parameter logic [N_WIDTHS-1:0] SUPPORT_MASK = 7'b0001111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] cap_max_width,
  input  logic [WIDTH_W-1:0] trained_width,
  input  logic               train_ok,
  output logic [WIDTH_W-1:0] width_q
);

  logic cap_sup;
  logic [WIDTH_W-1:0] width_d;

  assign cap_sup = width_supported(cap_max_width, SUPPORT_MASK);
  assign width_d = report_width(cap_max_width, trained_width, train_ok, SUPPORT_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) width_q <= '0;
    else        width_q <= width_d;
  end

  // R1: supported maximum and good training pass the trained width
  a_r1_trained_width: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sup && train_ok) |=> (width_q == $past(trained_width)));

  // R2: unsupported maximum is reported as configured
  a_r2_unsupported_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_sup |=> (width_q == $past(cap_max_width)));

  // R3: failed training on a supported maximum reads zero
  a_r3_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sup && !train_ok) |=> (width_q == '0));

endmodule

// File: rtl/lnk_train_flag.sv
module lnk_train_flag
  import lnk_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_downstream,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               retrain_wr,
  output logic               train_q
);

  logic in_train;
  logic pend_q;
  logic pend_d;
  logic train_d;

  assign in_train = is_training_state(ltssm_state);

  // A request waits until the LTSSM is seen in a training state
  assign pend_d  = is_downstream && (pend_q || retrain_wr) && !in_train;
  assign train_d = is_downstream && (in_train || retrain_wr || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      train_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      train_q <= train_d;
    end
  end

  // R4: training state on a downstream port raises the flag
  a_r4_state_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (is_downstream && in_train) |=> train_q);

  // R5: retrain request raises the flag before training starts
  a_r5_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (is_downstream && retrain_wr) |=> train_q);

  // R5: a request waiting for training keeps the flag up
  a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_downstream && pend_q) |=> train_q);

  // R6: upstream port never shows training
  a_r6_upstream_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !is_downstream |=> !train_q);

endmodule

// File: rtl/lnk_bw_status.sv
module lnk_bw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic is_downstream,
  input  logic cap_bw_notify,
  input  logic dl_active,
  input  logic retrain_done_evt,
  input  logic auto_change_evt,
  input  logic partner_change_evt,
  input  logic clr_req,
  output logic bw_q
);

  logic gate;
  logic set_evt;
  logic bw_d;

  assign gate    = is_downstream && cap_bw_notify;
  assign set_evt = gate && dl_active &&
                   (retrain_done_evt || auto_change_evt || partner_change_evt);
  // Set has priority over a same-cycle clear
  assign bw_d    = gate && (set_evt || (bw_q && !clr_req));

  always_ff @(posedge clk) begin
    if (!rst_n) bw_q <= 1'b0;
    else        bw_q <= bw_d;
  end

  // R8: a qualified event sets the bit
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> bw_q);

  // R8: a clear with no event empties the bit
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !bw_q);

  // R8: with no event and no clear the bit holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !set_evt && !clr_req) |=> (bw_q == $past(bw_q)));

  // R9: gated off reads zero
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !bw_q);

  // R10: same-cycle set and clear leaves the bit set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_req) |=> bw_q);

endmodule

// File: rtl/lnk_status_reg.sv
module lnk_status_reg
  import lnk_status_pkg::*;
#(
  parameter logic [N_WIDTHS-1:0] SUPPORT_MASK = 7'b0001111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_downstream,
  input  logic [WIDTH_W-1:0] cap_max_width,
  input  logic               cap_dll_report,
  input  logic               cap_bw_notify,
  input  logic               strap_common_clk,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic [WIDTH_W-1:0] trained_width,
  input  logic               train_ok,
  input  logic               dl_active,
  input  logic [SPEED_W-1:0] phy_speed,
  input  logic               retrain_done_evt,
  input  logic               auto_change_evt,
  input  logic               partner_change_evt,
  input  logic               retrain_wr,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               sclk_lock,
  output logic [REG_W-1:0]   rd_data
);

  logic [WIDTH_W-1:0] width_q;
  logic               train_q;
  logic               bw_q;
  logic               sclk_q;
  logic               dll_q;
  logic [SPEED_W-1:0] speed_q;
  logic               bw_clr;
  logic               sclk_wr;
  logic               unused_wr_bits;

  assign bw_clr  = wr_en && wr_data[POS_BW];
  assign sclk_wr = wr_en && !sclk_lock;
  assign unused_wr_bits = ^{wr_data[REG_W-1:POS_BW+1], wr_data[POS_DLL],
                            wr_data[POS_SCLK-1:0]};

  lnk_width_rpt #(.SUPPORT_MASK(SUPPORT_MASK)) u_width (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_max_width (cap_max_width),
    .trained_width (trained_width),
    .train_ok      (train_ok),
    .width_q       (width_q)
  );

  lnk_train_flag u_train (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_downstream (is_downstream),
    .ltssm_state   (ltssm_state),
    .retrain_wr    (retrain_wr),
    .train_q       (train_q)
  );

  lnk_bw_status u_bw (
    .clk                (clk),
    .rst_n              (rst_n),
    .is_downstream      (is_downstream),
    .cap_bw_notify      (cap_bw_notify),
    .dl_active          (dl_active),
    .retrain_done_evt   (retrain_done_evt),
    .auto_change_evt    (auto_change_evt),
    .partner_change_evt (partner_change_evt),
    .clr_req            (bw_clr),
    .bw_q               (bw_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= strap_common_clk;
      dll_q   <= 1'b0;
      speed_q <= '0;
    end else begin
      if (sclk_wr) sclk_q <= wr_data[POS_SCLK];
      dll_q   <= dl_active && cap_dll_report;
      speed_q <= phy_speed;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[POS_SPEED +: SPEED_W] = speed_q;
    rd_data[POS_WIDTH +: WIDTH_W] = width_q;
    rd_data[POS_TRAIN]            = train_q;
    rd_data[POS_SCLK]             = sclk_q;
    rd_data[POS_DLL]              = dll_q;
    rd_data[POS_BW]               = bw_q;
  end

  // R7: no reporting capability, no link-active bit
  a_r7_dll_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_dll_report |=> !rd_data[POS_DLL]);

  // R11: locked writes leave the slot clock bit alone
  a_r11_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sclk_lock) |=> $stable(rd_data[POS_SCLK]));

  // R11: unlocked write takes the written value
  a_r11_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sclk_lock) |=> (rd_data[POS_SCLK] == $past(wr_data[POS_SCLK])));

  // R12: reserved bits read zero
  a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (!rd_data[10] && !rd_data[15]));

endmodule

// File: tb/lnk_status_reg_bench.sv
`timescale 1ns/1ps
module lnk_status_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_downstream = 1'b0;
  logic [5:0]  cap_max_width = '0;
  logic        cap_dll_report = 1'b0;
  logic        cap_bw_notify = 1'b0;
  logic        strap_common_clk = 1'b1;
  logic [3:0]  ltssm_state = '0;
  logic [5:0]  trained_width = '0;
  logic        train_ok = 1'b0;
  logic        dl_active = 1'b0;
  logic [3:0]  phy_speed = '0;
  logic        retrain_done_evt = 1'b0;
  logic        auto_change_evt = 1'b0;
  logic        partner_change_evt = 1'b0;
  logic        retrain_wr = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sclk_lock = 1'b0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lnk_status_reg u_lnk_status_reg (
    .clk(clk), .rst_n(rst_n), .is_downstream(is_downstream),
    .cap_max_width(cap_max_width), .cap_dll_report(cap_dll_report),
    .cap_bw_notify(cap_bw_notify), .strap_common_clk(strap_common_clk),
    .ltssm_state(ltssm_state), .trained_width(trained_width),
    .train_ok(train_ok), .dl_active(dl_active), .phy_speed(phy_speed),
    .retrain_done_evt(retrain_done_evt), .auto_change_evt(auto_change_evt),
    .partner_change_evt(partner_change_evt), .retrain_wr(retrain_wr),
    .wr_en(wr_en), .wr_data(wr_data), .sclk_lock(sclk_lock),
    .rd_data(rd_data)
  );

  function automatic logic [5:0] code_of(input int i);
    logic [5:0] c;
    case (i)
      0: c = 6'd1;  1: c = 6'd2;  2: c = 6'd4;  3: c = 6'd8;
      4: c = 6'd12; 5: c = 6'd16; default: c = 6'd32;
    endcase
    return c;
  endfunction

  // Default support: x1, x2, x4, x8 only
  function automatic bit bench_sup(input logic [5:0] c);
    return (c == 6'd1) || (c == 6'd2) || (c == 6'd4) || (c == 6'd8);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12: reset value, only the strapped slot clock bit set
    chk("R12 reset", rd_data, 16'h1000);

    // R1 R2 R3: sweep configured maximum, trained width and outcome
    for (int c = 0; c < 7; c++) begin
      for (int t = 0; t < 7; t++) begin
        for (int ok = 0; ok < 2; ok++) begin
          logic [5:0] e;
          cap_max_width = code_of(c);
          trained_width = code_of(t);
          train_ok = ok[0];
          tick();
          if (!bench_sup(cap_max_width)) e = cap_max_width;
          else if (ok == 0)              e = 6'd0;
          else                           e = trained_width;
          chk(!bench_sup(cap_max_width) ? "R2 width" : (ok == 0 ? "R3 width" : "R1 width"),
              {10'd0, rd_data[9:4]}, {10'd0, e});
        end
      end
    end
    cap_max_width = 6'b000011;   // invalid code counts as unsupported
    trained_width = 6'd4;
    train_ok = 1'b1;
    tick();
    chk("R2 invalid code", {10'd0, rd_data[9:4]}, 16'h0003);
    cap_max_width = 6'd8;

    // R4 R6: every LTSSM code on both directions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 16; s++) begin
        is_downstream = d[0];
        ltssm_state = s[3:0];
        tick();
        chk(d == 1 ? "R4 train flag" : "R6 train flag", {15'd0, rd_data[11]},
            {15'd0, (d == 1) && (s == 2 || s == 4)});
      end
    end

    // R5: early set, held until training entered and left
    is_downstream = 1'b1;
    ltssm_state = 4'd3;
    tick();
    retrain_wr = 1'b1;
    tick();
    retrain_wr = 1'b0;
    chk("R5 early set", {15'd0, rd_data[11]}, 16'd1);
    tick();
    tick();
    chk("R5 held before training", {15'd0, rd_data[11]}, 16'd1);
    ltssm_state = 4'd4;
    tick();
    chk("R5 during recovery", {15'd0, rd_data[11]}, 16'd1);
    ltssm_state = 4'd3;
    tick();
    chk("R5 cleared after exit", {15'd0, rd_data[11]}, 16'd0);

    // R5: request while already in Recovery, no drop
    ltssm_state = 4'd4;
    tick();
    retrain_wr = 1'b1;
    tick();
    retrain_wr = 1'b0;
    chk("R5 no drop a", {15'd0, rd_data[11]}, 16'd1);
    tick();
    chk("R5 no drop b", {15'd0, rd_data[11]}, 16'd1);
    ltssm_state = 4'd3;
    tick();
    chk("R5 exit after recovery", {15'd0, rd_data[11]}, 16'd0);

    // R6: upstream ignores request
    is_downstream = 1'b0;
    retrain_wr = 1'b1;
    tick();
    retrain_wr = 1'b0;
    chk("R6 upstream request", {15'd0, rd_data[11]}, 16'd0);
    tick();
    chk("R6 upstream later", {15'd0, rd_data[11]}, 16'd0);

    // R7: link-active bit over both inputs
    for (int k = 0; k < 4; k++) begin
      cap_dll_report = k[1];
      dl_active = k[0];
      tick();
      chk("R7 link active", {15'd0, rd_data[13]}, {15'd0, k == 3});
    end

    // R8: each event source sets, clear by write-one
    is_downstream = 1'b1;
    cap_bw_notify = 1'b1;
    dl_active = 1'b1;
    for (int ev = 0; ev < 3; ev++) begin
      retrain_done_evt = (ev == 0);
      auto_change_evt = (ev == 1);
      partner_change_evt = (ev == 2);
      tick();
      retrain_done_evt = 1'b0;
      auto_change_evt = 1'b0;
      partner_change_evt = 1'b0;
      chk("R8 event set", {15'd0, rd_data[14]}, 16'd1);
      wr_en = 1'b1;
      sclk_lock = 1'b1;
      wr_data = 16'h0000;
      tick();
      chk("R8 write zero keeps", {15'd0, rd_data[14]}, 16'd1);
      wr_data = 16'h4000;
      tick();
      wr_en = 1'b0;
      chk("R8 write one clears", {15'd0, rd_data[14]}, 16'd0);
    end
    dl_active = 1'b0;
    auto_change_evt = 1'b1;
    tick();
    auto_change_evt = 1'b0;
    chk("R8 event while down", {15'd0, rd_data[14]}, 16'd0);
    dl_active = 1'b1;

    // R10: set and clear together
    wr_en = 1'b1;
    wr_data = 16'h4000;
    partner_change_evt = 1'b1;
    tick();
    wr_en = 1'b0;
    partner_change_evt = 1'b0;
    chk("R10 set wins", {15'd0, rd_data[14]}, 16'd1);

    // R9: gating by capability and direction
    cap_bw_notify = 1'b0;
    tick();
    chk("R9 cap off clears", {15'd0, rd_data[14]}, 16'd0);
    retrain_done_evt = 1'b1;
    tick();
    retrain_done_evt = 1'b0;
    chk("R9 cap off event", {15'd0, rd_data[14]}, 16'd0);
    cap_bw_notify = 1'b1;
    is_downstream = 1'b0;
    auto_change_evt = 1'b1;
    tick();
    auto_change_evt = 1'b0;
    chk("R9 upstream event", {15'd0, rd_data[14]}, 16'd0);

    // R11: lock behaviour, write data drives bit 12
    sclk_lock = 1'b0;
    wr_en = 1'b1;
    wr_data = 16'h0000;
    tick();
    chk("R11 unlocked write 0", {15'd0, rd_data[12]}, 16'd0);
    sclk_lock = 1'b1;
    wr_data = 16'h1000;
    tick();
    chk("R11 locked write 1", {15'd0, rd_data[12]}, 16'd0);
    sclk_lock = 1'b0;
    tick();
    wr_en = 1'b0;
    chk("R11 unlocked write 1", {15'd0, rd_data[12]}, 16'd1);

    // R12: speed field and reserved bits
    phy_speed = 4'd3;
    tick();
    chk("R12 speed", {12'd0, rd_data[3:0]}, 16'd3);
    chk("R12 reserved", {14'd0, rd_data[15], rd_data[10]}, 16'd0);

    // R11 R12: second reset with strap low
    strap_common_clk = 1'b0;
    is_downstream = 1'b0;
    cap_dll_report = 1'b0;
    dl_active = 1'b0;
    phy_speed = 4'd0;
    cap_max_width = 6'd0;
    do_reset();
    chk("R11 reset from strap 0", rd_data, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule